// File: doc/BRIEF.md
# Sideband Message Bus Bridge

This block turns register accesses from a host configuration port into messages on an internal sideband bus. Software writes a command word to the command register. That single write builds one message and launches it. The message carries an opcode, a destination port, a 32-bit register offset, byte enables and a 32-bit payload.

The low eight bits of the offset come from the command word. The upper 24 bits come from a separate offset-extension register, so endpoints with wide register spaces can be reached. The payload is the value held in the data register at the moment of launch. To write an endpoint register, software first fills the data register and then writes the command word with the write opcode (0x07).

To read an endpoint register, software writes the command word with a read opcode (for example 0x06). It then waits for the busy output to drop and reads the data register, which by then holds the returned value. The message side is a valid/ready master followed by a single-beat response channel.

Top module: `sbmb_bridge`

## Requirements
- R1: After reset, busy and msg_valid are low and the command, data and extension registers all read as zero.
- R2: A host write to the command register (address 0xD0) while busy is low raises msg_valid on the next cycle. The message fields are then: opcode = write data bits 31:24, port = bits 23:16, byte enables = bits 7:4, and offset = {extension register bits 31:8, write data bits 15:8}. Any opcode value is passed through unchanged.
- R3: While msg_valid is high and msg_ready is low, msg_valid stays high and every message field stays unchanged. msg_valid is low in the cycle after a cycle where msg_valid and msg_ready are both high.
- R4: msg_data equals the data register as it was just before the launching write. Host writes to the data or extension registers after launch do not alter the outstanding message.
- R5: busy rises with the launch and stays high until the cycle after rsp_valid is seen once the message has been accepted. While busy is high, a write to the command register starts no message and leaves the command readback unchanged.
- R6: A response to a message whose opcode is not 0x07 loads rsp_data into the data register (address 0xD4). A response to opcode 0x07 leaves the data register unchanged.
- R7: If a response that loads the data register arrives in the same cycle as a host write to the data register, the response value is kept.
- R8: host_rdata combinationally returns the register selected by host_addr. The command register reads back the accepted word with bits 3:0 forced to zero. The extension register (address 0xD8) reads back with bits 7:0 forced to zero. Any other address reads as zero.
- R9: Host writes to the data and extension registers take effect on the next cycle whether or not busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Configuration offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr |
| busy | output | 1 | A message is in flight |
| msg_valid | output | 1 | Message offered on the sideband bus |
| msg_ready | input | 1 | Bus accepts the message |
| msg_opcode | output | 8 | Message opcode |
| msg_port | output | 8 | Destination port |
| msg_offset | output | 32 | Register offset at the endpoint |
| msg_be | output | 4 | Byte enables |
| msg_data | output | 32 | Payload |
| rsp_valid | input | 1 | Response strobe, one cycle |
| rsp_data | input | 32 | Response data |

## Verification
The properties assume a well-behaved endpoint. It returns exactly one rsp_valid pulse per message, and only after the message has been accepted (busy high and msg_valid low). It never raises rsp_valid while the bridge is idle or still offering a message. The bench responder enforces this by arming a response only after it sees the valid/ready handshake, and then raising a single pulse after a programmable delay. The host issues one access at a time, which the bench drives from sequential tasks. Stimulus varies the ready stall and the response delay, including zero, and deliberately lines up a host data write with a response beat.

// File: rtl/sbmb_pkg.sv
package sbmb_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned OP_W   = 8;
    localparam int unsigned PORT_W = 8;
    localparam int unsigned BE_W   = 4;
    localparam int unsigned LOW_W  = 8;              // offset bits carried by the command word
    localparam int unsigned HIGH_W = WORD_W - LOW_W; // offset bits carried by the extension register
    localparam int unsigned RSV_W  = 4;              // reserved low bits of the command word

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } sb_state_e;

    typedef struct packed {
        logic [OP_W-1:0]   opcode;
        logic [PORT_W-1:0] port;
        logic [WORD_W-1:0] offset;
        logic [BE_W-1:0]   be;
        logic [WORD_W-1:0] data;
    } sb_msg_t;

    // cmd_hi is the command word without its reserved low bits
    function automatic sb_msg_t pack_msg(
        input logic [WORD_W-RSV_W-1:0] cmd_hi,
        input logic [HIGH_W-1:0]       ext_hi,
        input logic [WORD_W-1:0]       payload
    );
        sb_msg_t m;
        m.opcode = cmd_hi[WORD_W-RSV_W-1 -: OP_W];
        m.port   = cmd_hi[WORD_W-RSV_W-OP_W-1 -: PORT_W];
        m.offset = {ext_hi, cmd_hi[BE_W +: LOW_W]};
        m.be     = cmd_hi[BE_W-1:0];
        m.data   = payload;
        return m;
    endfunction

endpackage

// File: rtl/sbmb_regs.sv
module sbmb_regs
    import sbmb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CTRL_ADDR = 'hD0,
    parameter int unsigned DATA_ADDR = 'hD4,
    parameter int unsigned EXT_ADDR  = 'hD8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              busy,
    input  logic              rsp_load,
    input  logic [WORD_W-1:0] rsp_data,
    output logic              launch,
    output sb_msg_t           msg_next,
    output logic [WORD_W-1:0] data_o
);

    localparam logic [ADDR_W-1:0] CMD_A = CTRL_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DAT_A = DATA_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] EXT_A = EXT_ADDR[ADDR_W-1:0];

    typedef struct packed {
        logic [WORD_W-RSV_W-1:0] cmd;
        logic [HIGH_W-1:0]       ext;
        logic [WORD_W-1:0]       data;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_cmd, wr_dat, wr_ext;

    always_comb begin
        wr_cmd = host_sel && host_wr && (host_addr == CMD_A);
        wr_dat = host_sel && host_wr && (host_addr == DAT_A);
        wr_ext = host_sel && host_wr && (host_addr == EXT_A);
        launch = wr_cmd && !busy;

        r_d = r_q;
        if (launch) begin
            r_d.cmd = host_wdata[WORD_W-1:RSV_W];
        end
        if (wr_ext) begin
            r_d.ext = host_wdata[WORD_W-1:LOW_W];
        end
        if (wr_dat) begin
            r_d.data = host_wdata;
        end
        // a returning response takes precedence over a host data write
        if (rsp_load) begin
            r_d.data = rsp_data;
        end

        msg_next = pack_msg(host_wdata[WORD_W-1:RSV_W], r_q.ext, r_q.data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == CMD_A) begin
            host_rdata = {r_q.cmd, {RSV_W{1'b0}}};
        end else if (host_addr == DAT_A) begin
            host_rdata = r_q.data;
        end else if (host_addr == EXT_A) begin
            host_rdata = {r_q.ext, {LOW_W{1'b0}}};
        end
    end

    assign data_o = r_q.data;

endmodule

// File: rtl/sbmb_seq.sv
module sbmb_seq
    import sbmb_pkg::*;
#(
    parameter logic [OP_W-1:0] WRITE_OP = 8'h07
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    launch,
    input  sb_msg_t msg_next,
    input  logic    msg_ready,
    input  logic    rsp_valid,
    output sb_msg_t msg_q,
    output logic    msg_valid,
    output logic    busy,
    output logic    rsp_load
);

    typedef struct packed {
        sb_state_e st;
        sb_msg_t   msg;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (launch) begin
                    s_d.st  = ST_SEND;
                    s_d.msg = msg_next;
                end
            end
            ST_SEND: begin
                if (msg_ready) begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, msg: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign msg_q     = s_q.msg;
    assign msg_valid = (s_q.st == ST_SEND);
    assign busy      = (s_q.st != ST_IDLE);
    assign rsp_load  = (s_q.st == ST_WAIT) && rsp_valid && (s_q.msg.opcode != WRITE_OP);

endmodule

// File: rtl/sbmb_bridge.sv
module sbmb_bridge
    import sbmb_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 8,
    parameter int unsigned     CTRL_ADDR = 'hD0,
    parameter int unsigned     DATA_ADDR = 'hD4,
    parameter int unsigned     EXT_ADDR  = 'hD8,
    parameter logic [OP_W-1:0] WRITE_OP  = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              busy,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [OP_W-1:0]   msg_opcode,
    output logic [PORT_W-1:0] msg_port,
    output logic [WORD_W-1:0] msg_offset,
    output logic [BE_W-1:0]   msg_be,
    output logic [WORD_W-1:0] msg_data,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_data
);

    logic              launch;
    logic              rsp_load;
    sb_msg_t           msg_next;
    sb_msg_t           msg_q;
    logic [WORD_W-1:0] data_q;

    sbmb_regs #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .DATA_ADDR(DATA_ADDR),
        .EXT_ADDR (EXT_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_sel  (host_sel),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .busy      (busy),
        .rsp_load  (rsp_load),
        .rsp_data  (rsp_data),
        .launch    (launch),
        .msg_next  (msg_next),
        .data_o    (data_q)
    );

    sbmb_seq #(
        .WRITE_OP(WRITE_OP)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .msg_next (msg_next),
        .msg_ready(msg_ready),
        .rsp_valid(rsp_valid),
        .msg_q    (msg_q),
        .msg_valid(msg_valid),
        .busy     (busy),
        .rsp_load (rsp_load)
    );

    assign msg_opcode = msg_q.opcode;
    assign msg_port   = msg_q.port;
    assign msg_offset = msg_q.offset;
    assign msg_be     = msg_q.be;
    assign msg_data   = msg_q.data;

endmodule

// File: rtl/sbmb_bridge_chk.sv
module sbmb_bridge_chk #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CTRL_ADDR = 'hD0,
    parameter int unsigned DATA_ADDR = 'hD4,
    parameter logic [7:0]  WRITE_OP  = 8'h07
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [27:0]       wdata_hi,
    input logic [3:0]        rdata_lo,
    input logic              busy,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [7:0]        msg_opcode,
    input logic [7:0]        msg_port,
    input logic [31:0]       msg_offset,
    input logic [3:0]        msg_be,
    input logic [31:0]       msg_data,
    input logic              rsp_valid,
    input logic [31:0]       rsp_data,
    input logic [31:0]       data_q
);

    localparam logic [ADDR_W-1:0] CMD_A = CTRL_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DAT_A = DATA_ADDR[ADDR_W-1:0];

    logic cmd_wr, dat_wr;
    assign cmd_wr = host_sel && host_wr && (host_addr == CMD_A);
    assign dat_wr = host_sel && host_wr && (host_addr == DAT_A);

    AST_LAUNCH_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (msg_valid && msg_opcode == $past(wdata_hi[27:20])
            && msg_port == $past(wdata_hi[19:12]) && msg_be == $past(wdata_hi[3:0])
            && msg_offset[7:0] == $past(wdata_hi[11:4]))); // R2

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_opcode) && $stable(msg_port)
            && $stable(msg_offset) && $stable(msg_be) && $stable(msg_data))); // R3

    AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid); // R3

    AST_VALID_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> busy); // R5

    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !msg_valid) |=> !msg_valid); // R5

    AST_RSP_LOADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !msg_valid && rsp_valid && msg_opcode != WRITE_OP) |=> (data_q == $past(rsp_data))); // R6

    AST_WRITE_RSP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !msg_valid && rsp_valid && msg_opcode == WRITE_OP && !dat_wr) |=> $stable(data_q)); // R6

    AST_CMD_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == CMD_A) |-> (rdata_lo == 4'h0)); // R8

endmodule

bind sbmb_bridge sbmb_bridge_chk #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .DATA_ADDR(DATA_ADDR),
    .WRITE_OP (WRITE_OP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_sel  (host_sel),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .wdata_hi  (host_wdata[31:4]),
    .rdata_lo  (host_rdata[3:0]),
    .busy      (busy),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_opcode(msg_opcode),
    .msg_port  (msg_port),
    .msg_offset(msg_offset),
    .msg_be    (msg_be),
    .msg_data  (msg_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .data_q    (data_q)
);

// File: tb/tb_sbmb_bridge.sv
module tb_sbmb_bridge;

    localparam logic [7:0] A_CMD = 8'hD0;
    localparam logic [7:0] A_DAT = 8'hD4;
    localparam logic [7:0] A_EXT = 8'hD8;
    localparam logic [7:0] OP_RD = 8'h06;
    localparam logic [7:0] OP_WR = 8'h07;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy, msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_opcode, msg_port;
    logic [31:0] msg_offset, msg_data;
    logic [3:0]  msg_be;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;

    always #4 clk = ~clk; // 125 MHz

    sbmb_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_opcode(msg_opcode), .msg_port(msg_port), .msg_offset(msg_offset),
        .msg_be(msg_be), .msg_data(msg_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cmd, m_ext, m_data, m_off, m_pay;
    logic [7:0]  m_op, m_port;
    logic [3:0]  m_be;
    bit          m_valid, m_wait;

    function automatic logic [31:0] mread(input logic [7:0] a);
        if (a == A_CMD) return m_cmd;
        if (a == A_DAT) return m_data;
        if (a == A_EXT) return m_ext;
        return 32'h0;
    endfunction

    always @(posedge clk) begin : model
        bit was_busy, take, w_cmd, w_dat, w_ext;
        logic [31:0] old_data, old_ext;
        if (!rst_n) begin
            m_cmd = '0; m_ext = '0; m_data = '0; m_off = '0; m_pay = '0;
            m_op = '0; m_port = '0; m_be = '0; m_valid = 0; m_wait = 0;
        end else begin
            was_busy = m_valid || m_wait;
            old_data = m_data;
            old_ext  = m_ext;
            take  = m_wait && rsp_valid;
            w_cmd = host_sel && host_wr && host_addr == A_CMD;
            w_dat = host_sel && host_wr && host_addr == A_DAT;
            w_ext = host_sel && host_wr && host_addr == A_EXT;
            if (m_valid && msg_ready) begin
                m_valid = 0; m_wait = 1;
            end else if (take) begin
                m_wait = 0;
            end
            if (w_dat) m_data = host_wdata;
            if (take && m_op != OP_WR) m_data = rsp_data;
            if (w_ext) m_ext = {host_wdata[31:8], 8'h00};
            if (w_cmd && !was_busy) begin
                m_cmd   = {host_wdata[31:4], 4'h0};
                m_op    = host_wdata[31:24];
                m_port  = host_wdata[23:16];
                m_be    = host_wdata[7:4];
                m_off   = {old_ext[31:8], host_wdata[15:8]};
                m_pay   = old_data;
                m_valid = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(busy === (m_valid || m_wait), "R5 busy", {31'h0, busy}, {31'h0, m_valid || m_wait});
            check(msg_valid === m_valid, "R3 msg_valid", {31'h0, msg_valid}, {31'h0, m_valid});
            if (m_valid) begin
                check(msg_opcode === m_op, "R2 opcode", {24'h0, msg_opcode}, {24'h0, m_op});
                check(msg_port === m_port, "R2 port", {24'h0, msg_port}, {24'h0, m_port});
                check(msg_be === m_be, "R2 be", {28'h0, msg_be}, {28'h0, m_be});
                check(msg_offset === m_off, "R2 offset", msg_offset, m_off);
                check(msg_data === m_pay, "R4 payload", msg_data, m_pay);
            end
            check(host_rdata === mread(host_addr), "R8 readback", host_rdata, mread(host_addr));
        end
    end

    // ---------------- endpoint responder ----------------
    int unsigned ready_gap = 0;
    int unsigned rsp_gap = 2;
    int unsigned rsp_seq = 0;
    logic [31:0] last_rsp = '0;
    bit hs_n = 0;

    always @(negedge clk) hs_n = msg_valid && msg_ready;

    always @(posedge clk) begin : responder
        int unsigned dly, rcnt;
        bit pend;
        #2;
        rsp_valid = 1'b0;
        if (!rst_n) begin
            pend = 0; dly = 0; rcnt = 0; msg_ready = 1'b0;
        end else begin
            if (hs_n) begin
                pend = 1; dly = rsp_gap;
            end else if (pend) begin
                if (dly == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = 32'hC0DE_0000 + rsp_seq * 32'h0101_0013;
                    last_rsp  = rsp_data;
                    rsp_seq++;
                    pend = 0;
                end else begin
                    dly--;
                end
            end
            if (msg_valid && !msg_ready) begin
                if (rcnt >= ready_gap) msg_ready = 1'b1;
                else rcnt++;
            end else begin
                msg_ready = 1'b0; rcnt = 0;
            end
        end
    end

    // ---------------- host tasks ----------------
    task automatic hw(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(posedge clk); #2;
        host_sel = 0; host_wr = 0;
    endtask

    task automatic hrd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        host_sel = 1; host_wr = 0; host_addr = a;
        #1;
        check(host_rdata === exp, tag, host_rdata, exp);
        host_sel = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        check(busy === 1'b0 && msg_valid === 1'b0, "R1 reset outputs", {30'h0, busy, msg_valid}, 32'h0);
        hrd(A_CMD, 32'h0, "R1 cmd reset");
        hrd(A_DAT, 32'h0, "R1 data reset");
        hrd(A_EXT, 32'h0, "R1 ext reset");
        hrd(8'h10, 32'h0, "R8 unmapped address");

        hw(A_EXT, 32'h1234_5678);
        hrd(A_EXT, 32'h1234_5600, "R9 ext write / R8 low byte zero");
        hw(A_DAT, 32'hDEAD_BEEF);
        hrd(A_DAT, 32'hDEAD_BEEF, "R9 data write");

        // read message with all byte enables
        ready_gap = 2; rsp_gap = 1;
        hw(A_CMD, {OP_RD, 8'h2A, 8'h3C, 4'hF, 4'h5});
        check(msg_valid === 1'b1 && busy === 1'b1, "R5 busy at launch", {30'h0, msg_valid, busy}, 32'h3);
        check(msg_opcode === OP_RD && msg_port === 8'h2A && msg_be === 4'hF, "R2 fields",
              {8'h0, msg_opcode, msg_port, 4'h0, msg_be}, {8'h0, OP_RD, 8'h2A, 4'h0, 4'hF});
        check(msg_offset === 32'h1234_563C, "R2 joined offset", msg_offset, 32'h1234_563C);
        check(msg_data === 32'hDEAD_BEEF, "R4 payload at launch", msg_data, 32'hDEAD_BEEF);
        hrd(A_CMD, 32'h062A_3CF0, "R8 cmd reserved bits");
        wait_idle();
        hrd(A_DAT, last_rsp, "R6 read response latched");

        // write message, writes during flight
        ready_gap = 4; rsp_gap = 5;
        hw(A_DAT, 32'h1111_2222);
        hw(A_CMD, {OP_WR, 8'h05, 8'h10, 4'h3, 4'h0});
        check(msg_offset === 32'h1234_5610 && msg_data === 32'h1111_2222, "R4 write payload",
              msg_data, 32'h1111_2222);
        hw(A_DAT, 32'h3333_4444);
        hw(A_EXT, 32'hFFFF_FF99);
        check(msg_data === 32'h1111_2222 && msg_offset === 32'h1234_5610, "R4 message isolated",
              msg_offset, 32'h1234_5610);
        hw(A_CMD, {8'h06, 8'h99, 8'h99, 4'h9, 4'h0});
        hrd(A_CMD, 32'h0705_1030, "R5 cmd write ignored while busy");
        wait_idle();
        @(negedge clk);
        check(msg_valid === 1'b0, "R5 no message from ignored write", {31'h0, msg_valid}, 32'h0);
        hrd(A_DAT, 32'h3333_4444, "R6 write response keeps data");
        hrd(A_EXT, 32'hFFFF_FF00, "R9 ext write while busy");

        // collision of response and host data write
        ready_gap = 0; rsp_gap = 3;
        hw(A_CMD, {OP_RD, 8'h01, 8'h02, 4'hF, 4'h0});
        for (int i = 0; i < 50; i++) begin
            @(posedge clk); #3;
            if (rsp_valid) break;
        end
        host_sel = 1; host_wr = 1; host_addr = A_DAT; host_wdata = 32'h5555_5555;
        @(posedge clk); #2;
        host_sel = 0; host_wr = 0;
        wait_idle();
        hrd(A_DAT, last_rsp, "R7 response beats host write");

        // back-to-back reads with zero stalls
        rsp_gap = 0;
        for (int k = 0; k < 5; k++) begin
            hw(A_CMD, {OP_RD, 8'(k + 3), 8'(k * 16 + 1), 4'hF, 4'h0});
            wait_idle();
            hrd(A_DAT, last_rsp, "R6 back-to-back read");
        end

        // other opcode passes through; new extension
        hw(A_EXT, 32'hABCD_EF00);
        hw(A_CMD, {8'h10, 8'h44, 8'h77, 4'h1, 4'h0});
        check(msg_opcode === 8'h10, "R2 opcode passthrough", {24'h0, msg_opcode}, 32'h10);
        check(msg_offset === 32'hABCD_EF77, "R2 extended offset", msg_offset, 32'hABCD_EF77);
        wait_idle();
        hrd(A_DAT, last_rsp, "R6 other opcode latches");

        repeat (3) @(posedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule